// File: doc/BRIEF.md
# Two-Wire Serial Write Master

This block converts one parallel write request into a serial transaction on a narrow link. The link has a request strobe, a two-bit data path and an acknowledge input from the target. The user presents a 17-bit address, a write word and a one-cycle start pulse. The block then raises the request line and sends a fixed frame, two bits per cycle. The frame holds a write marker, the address and the data. After the request drops, the block waits for the target to acknowledge.

The write word is 32 or 8 bits wide, chosen by the `DATA_W` parameter. The frame therefore lasts 25 or 13 cycles. Its first cycle pairs the write marker with the lowest address bit, which is why the frame length is odd.

Only one write is in flight at a time. `busy_o` covers the whole transaction. Completion is reported by a one-cycle `done_o` pulse. If the target stays silent for `ACK_TIMEOUT` cycles, a one-cycle `err_o` pulse is reported instead and the block returns to idle.

Top module: `pair_bus_writer`

## Requirements
- R1: `link_req_o` is high for exactly (1 + 17 + DATA_W) / 2 consecutive cycles per accepted write (25 for DATA_W=32, 13 for DATA_W=8), then low.
- R2: In the first request cycle, `link_dat_o[0]` is 1 (write marker) and `link_dat_o[1]` carries address bit 0.
- R3: In request cycles 2 to 9, cycle n carries address bit 2(n-1) on `link_dat_o[1]` and address bit 2(n-1)-1 on `link_dat_o[0]`, ending with bits 16 and 15.
- R4: From request cycle 10 on, the data goes out lowest pair first: data bit 2j+1 on `link_dat_o[1]` and data bit 2j on `link_dat_o[0]`, for j = 0 to DATA_W/2-1.
- R5: `link_dat_o` is 2'b00 whenever `link_req_o` is low. After reset, all outputs are low.
- R6: `link_ack_i` is acted on only after the request has dropped. When it is sampled high in that phase, `done_o` is high for exactly the next cycle and `busy_o` goes low in the same cycle. An acknowledge while `link_req_o` is high is ignored.
- R7: A start pulse is accepted only when idle. `busy_o` and `link_req_o` rise in the cycle after acceptance. A start pulse while busy changes neither the frame nor the outcome.
- R8: If no acknowledge is sampled in the ACK_TIMEOUT cycles after the request drops, `err_o` pulses for one cycle and `busy_o` falls with it. An acknowledge in the last of those cycles still completes with `done_o`. A new write is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a write |
| addr_i | input | 17 | Write address, sampled with an accepted start |
| wdata_i | input | DATA_W | Write data, sampled with an accepted start |
| busy_o | output | 1 | A write is in flight |
| done_o | output | 1 | One-cycle pulse: the target acknowledged |
| err_o | output | 1 | One-cycle pulse: acknowledge timeout |
| link_req_o | output | 1 | Link request strobe |
| link_dat_o | output | 2 | Link data pair |
| link_ack_i | input | 1 | Target acknowledge |

## Verification
A start sampled at clock edge E0 shows its first pair on the link right after E0. Pair k follows edge E0+k, and the request falls at edge E0+P, where P is the frame length. An acknowledge driven in the n-th cycle after the request falls is sampled at the next edge, so `done_o` appears in cycle n+1. With no acknowledge, `err_o` appears in cycle ACK_TIMEOUT+1. The bench drives inputs on falling edges and samples outputs on falling edges. It counts those cycles per lane from the observed fall of the request and compares in exactly the cycle each result is due. The 32-bit and 8-bit variants run side by side on the same stimulus.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int ADDR_W = 17;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT
  } pbw_state_e;

  // marker bit + address + data, sent two bits per cycle
  function automatic int frame_pairs(input int data_w);
    return (1 + ADDR_W + data_w) / 2;
  endfunction
endpackage

// File: rtl/pbw_shifter.sv
module pbw_shifter #(
  parameter int FRAME_W = 50,
  parameter int PAIRS   = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic               clear,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [1:0]         pair_o,
  output logic               last_o
);
  localparam int CNT_W = (PAIRS > 2) ? $clog2(PAIRS) : 1;

  logic [FRAME_W-1:0] rest_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q <= '0;
      left_q <= '0;
      pair_o <= 2'b00;
    end else if (load) begin
      pair_o <= frame_i[1:0];
      rest_q <= frame_i >> 2;
      left_q <= CNT_W'(PAIRS - 1);
    end else if (shift) begin
      pair_o <= rest_q[1:0];
      rest_q <= rest_q >> 2;
      left_q <= left_q - 1'b1;
    end else if (clear) begin
      pair_o <= 2'b00;
    end
  end

  assign last_o = (left_q == '0);
endmodule

// File: rtl/pbw_ack_timer.sv
module pbw_ack_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired_o
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/pair_bus_writer.sv
module pair_bus_writer
  import pbw_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              link_req_o,
  output logic [1:0]        link_dat_o,
  input  logic              link_ack_i
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int PAIRS   = frame_pairs(DATA_W);

  pbw_state_e state_q;
  logic       last;
  logic       expired;
  logic       do_load;
  logic       do_shift;
  logic       do_clear;
  logic       waiting;
  logic [FRAME_W-1:0] frame;

  // lowest pair first: {A0, marker}, then address pairs, then data pairs
  assign frame    = {wdata_i, addr_i, 1'b1};
  assign do_load  = (state_q == ST_IDLE) && start_i;
  assign do_shift = (state_q == ST_SEND) && !last;
  assign do_clear = (state_q == ST_SEND) && last;
  assign waiting  = (state_q == ST_WAIT);

  pbw_shifter #(
    .FRAME_W(FRAME_W),
    .PAIRS  (PAIRS)
  ) u_shifter (
    .clk    (clk),
    .rst    (rst),
    .load   (do_load),
    .shift  (do_shift),
    .clear  (do_clear),
    .frame_i(frame),
    .pair_o (link_dat_o),
    .last_o (last)
  );

  pbw_ack_timer #(
    .LIMIT(ACK_TIMEOUT)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (waiting),
    .expired_o(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      link_req_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_SEND;
            link_req_o <= 1'b1;
            busy_o     <= 1'b1;
          end
        end
        ST_SEND: begin
          if (last) begin
            state_q    <= ST_WAIT;
            link_req_o <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (link_ack_i) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
          end else if (expired) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            err_o   <= 1'b1;
          end
        end
        default: begin
          state_q    <= ST_IDLE;
          link_req_o <= 1'b0;
          busy_o     <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker
  import pbw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       link_req_o,
  input logic [1:0] link_dat_o,
  input logic       link_ack_i
);
  localparam int PAIRS = frame_pairs(DATA_W);
  localparam int RW    = $clog2(PAIRS + 2);

  // consecutive earlier cycles with the request high
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !link_req_o) run_q <= '0;
    else                    run_q <= run_q + 1'b1;
  end

  a_r1_no_overrun: assert property (@(posedge clk) disable iff (rst)
    link_req_o |-> (run_q < RW'(PAIRS)));

  a_r1_full_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(link_req_o) |-> (run_q == RW'(PAIRS)));

  a_r2_write_marker: assert property (@(posedge clk) disable iff (rst)
    $rose(link_req_o) |-> link_dat_o[0]);

  a_r5_quiet_lines: assert property (@(posedge clk) disable iff (rst)
    !link_req_o |-> (link_dat_o == 2'b00));

  a_r6_done_cause: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(link_ack_i) && !$past(link_req_o) && !busy_o));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_start_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(start_i) && link_req_o));

  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!done_o && !busy_o && !$past(link_ack_i)));
endmodule

bind pair_bus_writer pbw_checker #(.DATA_W(DATA_W)) u_pbw_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .link_req_o(link_req_o),
  .link_dat_o(link_dat_o),
  .link_ack_i(link_ack_i)
);

// File: tb/test_pair_bus_writer.sv
module test_pair_bus_writer;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 6;
  localparam int PAIRS32    = 25;
  localparam int PAIRS8     = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;

  logic       busy0, done0, err0, req0, ack0;
  logic       busy1, done1, err1, req1, ack1;
  logic [1:0] dat0, dat1;

  int  ack_dly   = 0;
  bit  spur_req  = 1'b0;
  int  drv_cmp   = 0;
  int  drv_bad   = 0;
  bit  finished  = 1'b0;

  logic [1:0] exq0[$];
  logic [1:0] exq1[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_bus_writer #(.DATA_W(32), .ACK_TIMEOUT(TMO)) i_pair_bus_writer (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy0), .done_o(done0), .err_o(err0),
    .link_req_o(req0), .link_dat_o(dat0), .link_ack_i(ack0)
  );

  pair_bus_writer #(.DATA_W(8), .ACK_TIMEOUT(TMO)) i_pair_bus_writer_n8 (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(addr), .wdata_i(wdata[7:0]),
    .busy_o(busy1), .done_o(done1), .err_o(err1),
    .link_req_o(req1), .link_dat_o(dat1), .link_ack_i(ack1)
  );

  function automatic logic [1:0] pair_of(input int w, input logic [16:0] a,
                                         input logic [31:0] d, input int k);
    logic [49:0] f;
    if (w == 32) f = {d, a, 1'b1};
    else         f = {24'd0, d[7:0], a, 1'b1};
    return f[2*k +: 2];
  endfunction

  task automatic dchk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    drv_cmp++;
    if (!ok) begin
      drv_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor / target model per lane: lane 0 is 32-bit, lane 1 is 8-bit
  for (genvar g = 0; g < 2; g++) begin : lane
    localparam int LP = (g == 0) ? PAIRS32 : PAIRS8;
    localparam int LW = (g == 0) ? 32 : 8;
    logic       lreq, lbusy, ldone, lerr;
    logic [1:0] ldat;
    logic       ackr = 1'b0;
    int cmp_l = 0, bad_l = 0, run = 0, w = 0, phase = 0;
    bit prev_ack = 1'b0, spurred = 1'b0;

    if (g == 0) begin : c0
      assign lreq = req0; assign lbusy = busy0; assign ldone = done0;
      assign lerr = err0; assign ldat = dat0;   assign ack0 = ackr;
    end else begin : c1
      assign lreq = req1; assign lbusy = busy1; assign ldone = done1;
      assign lerr = err1; assign ldat = dat1;   assign ack1 = ackr;
    end

    task automatic lchk(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      cmp_l++;
      if (!ok) begin
        bad_l++;
        $display("FAIL %s lane%0d %s: actual %0h expected %0h", rq, LW, what, act, exp);
      end
    endtask

    always @(negedge clk) begin
      logic [1:0] ex;
      string      tag;
      int         qn;
      if (!rst) begin
        if (lreq) begin
          if (phase != 1) begin phase = 1; run = 0; spurred = 1'b0; end
          run++;
          lchk(run <= LP, "R1", "request too long", run, LP);
          qn = (g == 0) ? exq0.size() : exq1.size();
          if (qn == 0) begin
            lchk(1'b0, "R7", "unrequested frame pair", ldat, 0);
          end else begin
            ex  = (g == 0) ? exq0.pop_front() : exq1.pop_front();
            tag = (run == 1) ? "R2" : ((run <= 9) ? "R3" : "R4");
            lchk(ldat == ex, tag, $sformatf("pair %0d", run), ldat, ex);
          end
          lchk(!ldone && !lerr, "R6", "done/err during frame", {ldone, lerr}, 0);
          ackr = spur_req && !spurred && (run == 3);  // ack while request high
          if (ackr) spurred = 1'b1;
          prev_ack = 1'b0;
        end else begin
          lchk(ldat == 2'b00, "R5", "data lines with request low", ldat, 0);
          if (phase == 1) begin
            lchk(run == LP, "R1", "request length", run, LP);
            phase = 2;
            w = 0;
          end
          if (phase == 2) begin
            w++;
            lchk(ldone == prev_ack, "R6", "done timing", ldone, prev_ack);
            if (prev_ack) begin
              lchk(!lbusy, "R6", "busy after done", lbusy, 0);
              phase = 0;
            end else if (ack_dly < 0 && w == TMO + 1) begin
              lchk(lerr && !lbusy, "R8", "timeout err/busy", {lerr, lbusy}, 2'b10);
              phase = 0;
            end else begin
              lchk(!lerr, "R8", "early error", lerr, 0);
            end
            ackr = (phase == 2) && (ack_dly >= 0) && (w == ack_dly + 1);
            prev_ack = ackr;
          end else begin
            lchk(!ldone && !lerr, "R6", "pulse while idle", {ldone, lerr}, 0);
            ackr = 1'b0;
            prev_ack = 1'b0;
          end
        end
      end
    end
  end

  task automatic send(input logic [16:0] a, input logic [31:0] d, input int dly,
                      input bit spur, input bit dup);
    while (busy0 || busy1) @(negedge clk);
    repeat (2) @(negedge clk);
    ack_dly  = dly;
    spur_req = spur;
    for (int k = 0; k < PAIRS32; k++) exq0.push_back(pair_of(32, a, d, k));
    for (int k = 0; k < PAIRS8; k++)  exq1.push_back(pair_of(8, a, d, k));
    addr  = a;
    wdata = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dchk(busy0 && busy1 && req0 && req1, "R7", "busy/request after start",
         {busy0, busy1, req0, req1}, 4'hF);
    if (dup) begin
      repeat (3) @(negedge clk);
      addr  = ~a;
      wdata = ~d;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dchk(busy0 && busy1, "R7", "busy held over second start", {busy0, busy1}, 2'b11);
    end
    @(negedge clk);
    while (busy0 || busy1) @(negedge clk);
    repeat (3) @(negedge clk);
    dchk(exq0.size() == 0 && exq1.size() == 0, "R1", "all expected pairs sent",
         exq0.size() + exq1.size(), 0);
    dchk(!req0 && !req1 && !busy0 && !busy1, "R7", "no frame from ignored start",
         {req0, req1, busy0, busy1}, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    dchk({busy0, done0, err0, req0, dat0} == 0 && {busy1, done1, err1, req1, dat1} == 0,
         "R5", "outputs after reset", {busy0, done0, err0, req0, dat0}, 0);
    send(17'h1A5C3, 32'hDEADBEEF, 0, 1'b0, 1'b0);         // R2 R3 R4 R6
    send(17'h00001, 32'h80000001, 2, 1'b0, 1'b1);         // R7 start while busy
    send(17'h1FFFF, 32'h00000000, TMO - 1, 1'b1, 1'b0);   // R8 last ack cycle, R6 early ack
    send(17'h0AAAA, 32'h5555AAAA, -1, 1'b0, 1'b0);        // R8 timeout
    send(17'h10000, 32'hFFFFFFFF, 1, 1'b0, 1'b0);         // R8 recovery after error
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             drv_cmp + lane[0].cmp_l + lane[1].cmp_l,
             drv_bad + lane[0].bad_l + lane[1].bad_l);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               drv_cmp + lane[0].cmp_l + lane[1].cmp_l + 1,
               drv_bad + lane[0].bad_l + lane[1].bad_l + 1);
      $finish;
    end
  end
endmodule